// File: doc/BRIEF.md
# Bit-Serial Adder/Subtractor with Parallel Operand Load

This block adds or subtracts two unsigned operands one bit per clock with a single full adder. The operands are first captured in parallel into an accumulator register (operand A) and a rotating register (operand B). The block then steps through the bit positions, least significant first. On each step the sum bit enters the top of the accumulator while the accumulator moves one place toward its low end. The carry is kept in a flip-flop between steps. The B register rotates, so after a full run it holds the loaded B value again.

Subtraction is the sum of A, the bitwise inverse of B and a carry-in of one. The carry flip-flop is preset to one at load time and every serial B bit is inverted before the adder. The operation is latched when the operands are loaded. After the final carry is produced, a done flag rises and the result and carry stay frozen until the next load.

A small state machine sequences the work. It has three states. IDLE is entered at reset, and shift cycles do nothing there. RUN steps one bit per shift cycle. DONE holds the result. Load mode moves every state to RUN and clears the step counter; this covers IDLE→RUN, RUN→RUN (restart) and DONE→RUN. The last step in RUN moves to DONE. A shift cycle leaves IDLE and DONE unchanged.

Top module: `serial_addsub`

## Requirements
- R1: A synchronous active-high reset clears the result to 0, carry_out to 0 and done to 0. It returns the block to IDLE.
- R2: A clock edge with load_mode=1 captures a_in into the accumulator (seen on result) and b_in into the B register. At that edge the carry flip-flop is preset to sub_mode (0 for add, 1 for subtract), done is cleared, and no shifting takes place.
- R3: In add mode (sub_mode=0 at load), exactly W=4 shift cycles after the load, done is 1, result equals (A+B) mod 16 and carry_out equals bit 4 of A+B.
- R4: After k shift cycles (1≤k≤4), result[3:4-k] holds the low k bits of the sum, with the least significant bit computed first. result[3-k:0] holds A shifted right by k.
- R5: After k shift cycles, carry_out equals the carry out of bit position k-1 of the serial addition (the carry into bit k).
- R6: The B register rotates right once per shift cycle, so the adder sees B bit k on step k+1 and B is intact after the run.
- R7: In subtract mode, after 4 shift cycles result equals (A−B) mod 16 and carry_out is 1 exactly when A≥B (no borrow).
- R8: The operation is fixed at load time. sub_mode has no effect during shift cycles.
- R9: After the fourth shift cycle, done stays 1 and further shift cycles leave result and carry_out unchanged until the next load.
- R10: Shift cycles after reset and before any load are ignored. done stays 0 however many are applied.
- R11: A load during a run restarts the block. done goes to 0, the new operands and preset carry are taken, and four further shift cycles give the new result.
- R12: Holding load_mode high for several cycles performs no steps. The operands present at the last load edge are the ones used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| load_mode | input | 1 | 1 = parallel load, 0 = shift (one bit step) |
| sub_mode | input | 1 | Operation taken at load: 0 add, 1 subtract |
| a_in | input | W | Parallel operand A |
| b_in | input | W | Parallel operand B |
| result | output | W | Accumulator contents; the result once done is 1 |
| carry_out | output | 1 | Carry flip-flop; final carry (no-borrow in subtract) at done |
| done | output | 1 | High in DONE, after the last step of a run |

## Verification
The accumulator and the carry flip-flop drive the ports directly, so a fault in the shift path, the B rotation or the carry update shows up on result or carry_out at the very step where it happens. The bench therefore compares the partially built result and the carry after every step, not only at the end. A step counter or state machine that is off by one shows up as done rising a cycle early or late. It also shows up as a result that moves after done, which is visible one edge after the extra shift. A subtract selection that is lost or re-read shows up in the preset carry on the cycle right after the load.

// File: rtl/sas_pkg.sv
package sas_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } sas_state_e;
endpackage

// File: rtl/sas_ctrl.sv
module sas_ctrl
    import sas_pkg::*;
#(
    parameter int W = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic load_mode,
    output logic ld_en,
    output logic step_en,
    output logic done
);
    localparam int CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    sas_state_e      state_q, state_d;
    logic [CW-1:0]   cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (load_mode) begin
            state_d = ST_RUN;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_RUN: begin
                    if (cnt_q == LAST) begin
                        state_d = ST_DONE;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = CW'(cnt_q + 1'b1);
                    end
                end
                ST_DONE: state_d = ST_DONE;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        ld_en   = load_mode;
        step_en = 1'b0;
        done    = 1'b0;
        unique case (state_q)
            ST_IDLE: step_en = 1'b0;
            ST_RUN:  step_en = !load_mode;
            ST_DONE: done    = 1'b1;
            default: step_en = 1'b0;
        endcase
    end

    // R3
    done_after_run_chk: assert property (@(posedge clk) disable iff (rst)
        (step_en && cnt_q == LAST) |=> done);
    // R9
    done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !load_mode) |=> (done && !step_en));
    // R11
    load_restart_chk: assert property (@(posedge clk) disable iff (rst)
        load_mode |=> (!done && cnt_q == '0));
    // R10
    idle_stays_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && !load_mode) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/sas_acc_reg.sv
module sas_acc_reg #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld_en,
    input  logic         step_en,
    input  logic [W-1:0] par_in,
    input  logic         sum_bit,
    output logic [W-1:0] acc_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (ld_en) begin
            acc_q <= par_in;
        end else if (step_en) begin
            acc_q <= {sum_bit, acc_q[W-1:1]};
        end
    end

    // R4
    acc_shift_chk: assert property (@(posedge clk) disable iff (rst)
        step_en |=> (acc_q[W-2:0] == $past(acc_q[W-1:1])));
    // R2
    acc_load_chk: assert property (@(posedge clk) disable iff (rst)
        ld_en |=> (acc_q == $past(par_in)));
endmodule

// File: rtl/sas_rot_reg.sv
module sas_rot_reg #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld_en,
    input  logic         step_en,
    input  logic [W-1:0] par_in,
    output logic         lsb
);
    logic [W-1:0] rot_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rot_q <= '0;
        end else if (ld_en) begin
            rot_q <= par_in;
        end else if (step_en) begin
            rot_q <= {rot_q[0], rot_q[W-1:1]};
        end
    end

    assign lsb = rot_q[0];

    // R6
    rot_keeps_bits_chk: assert property (@(posedge clk) disable iff (rst)
        step_en |=> ($countones(rot_q) == $countones($past(rot_q))));
    // R6
    rot_order_chk: assert property (@(posedge clk) disable iff (rst)
        step_en |=> (rot_q[W-1] == $past(rot_q[0])));
endmodule

// File: rtl/sas_bit_alu.sv
module sas_bit_alu (
    input  logic clk,
    input  logic rst,
    input  logic ld_en,
    input  logic step_en,
    input  logic sub_in,
    input  logic a_bit,
    input  logic b_bit,
    output logic sum_bit,
    output logic carry_q
);
    logic op_sub_q;
    logic b_eff;
    logic c_next;

    always_comb begin
        b_eff   = b_bit ^ op_sub_q;
        sum_bit = a_bit ^ b_eff ^ carry_q;
        c_next  = (a_bit & b_eff) | (carry_q & (a_bit ^ b_eff));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            carry_q  <= 1'b0;
            op_sub_q <= 1'b0;
        end else if (ld_en) begin
            carry_q  <= sub_in;
            op_sub_q <= sub_in;
        end else if (step_en) begin
            carry_q  <= c_next;
        end
    end

    // R2
    carry_preset_chk: assert property (@(posedge clk) disable iff (rst)
        ld_en |=> (carry_q == $past(sub_in)));
    // R8
    op_fixed_chk: assert property (@(posedge clk) disable iff (rst)
        !ld_en |=> $stable(op_sub_q));
endmodule

// File: rtl/serial_addsub.sv
module serial_addsub #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_mode,
    input  logic         sub_mode,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] result,
    output logic         carry_out,
    output logic         done
);
    logic ld_en;
    logic step_en;
    logic sum_bit;
    logic b_lsb;
    logic [W-1:0] acc;

    sas_ctrl #(.W(W)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .load_mode(load_mode),
        .ld_en    (ld_en),
        .step_en  (step_en),
        .done     (done)
    );

    sas_acc_reg #(.W(W)) u_acc (
        .clk    (clk),
        .rst    (rst),
        .ld_en  (ld_en),
        .step_en(step_en),
        .par_in (a_in),
        .sum_bit(sum_bit),
        .acc_q  (acc)
    );

    sas_rot_reg #(.W(W)) u_rot (
        .clk    (clk),
        .rst    (rst),
        .ld_en  (ld_en),
        .step_en(step_en),
        .par_in (b_in),
        .lsb    (b_lsb)
    );

    sas_bit_alu u_alu (
        .clk    (clk),
        .rst    (rst),
        .ld_en  (ld_en),
        .step_en(step_en),
        .sub_in (sub_mode),
        .a_bit  (acc[0]),
        .b_bit  (b_lsb),
        .sum_bit(sum_bit),
        .carry_q(carry_out)
    );

    assign result = acc;

    // R9
    frozen_after_done_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !load_mode) |=> ($stable(result) && $stable(carry_out)));
    // R12
    load_no_step_chk: assert property (@(posedge clk) disable iff (rst)
        load_mode |=> (result == $past(a_in)));
endmodule

// File: tb/sim_serial_addsub.sv
module sim_serial_addsub;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       load_mode = 1'b0;
    logic       sub_mode = 1'b0;
    logic [3:0] a_in = '0;
    logic [3:0] b_in = '0;
    logic [3:0] result;
    logic       carry_out;
    logic       done;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    serial_addsub #(.W(4)) u0 (
        .clk(clk), .rst(rst), .load_mode(load_mode), .sub_mode(sub_mode),
        .a_in(a_in), .b_in(b_in), .result(result), .carry_out(carry_out), .done(done)
    );

    // {a, b, sub, expected result, expected carry}
    localparam logic [13:0] VEC [10] = '{
        {4'd3,  4'd5, 1'b0, 4'd8,  1'b0},
        {4'd9,  4'd8, 1'b0, 4'd1,  1'b1},
        {4'd15, 4'd15,1'b0, 4'd14, 1'b1},
        {4'd0,  4'd0, 1'b0, 4'd0,  1'b0},
        {4'd10, 4'd6, 1'b0, 4'd0,  1'b1},
        {4'd7,  4'd3, 1'b1, 4'd4,  1'b1},
        {4'd3,  4'd7, 1'b1, 4'd12, 1'b0},
        {4'd5,  4'd5, 1'b1, 4'd0,  1'b1},
        {4'd0,  4'd1, 1'b1, 4'd15, 1'b0},
        {4'd15, 4'd0, 1'b1, 4'd15, 1'b1}
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // drive at a falling edge, sample at the next falling edge
    task automatic tick(input logic lm, input logic sm, input logic [3:0] a, input logic [3:0] b);
        load_mode = lm; sub_mode = sm; a_in = a; b_in = b;
        @(negedge clk);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #(200000 * 20);
        n_bad++;
        $display("FAIL R3 watchdog expired actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 result", result, 0);
        chk("R1 carry", carry_out, 0);
        chk("R1 done", done, 0);

        // R10 shifts before any load ignored
        for (int k = 0; k < 6; k++) tick(1'b0, 1'b0, 4'd9, 4'd9);
        chk("R10 done stays low", done, 0);
        chk("R10 result", result, 0);

        // table walk
        for (int i = 0; i < 10; i++) begin
            logic [13:0] v;
            int a, b, s, beff;
            v = VEC[i];
            a = v[13:10]; b = v[9:6]; s = v[5];
            beff = s ? ((~b) & 15) : b;
            tick(1'b1, s[0], v[13:10], v[9:6]);
            chk("R2 load result", result, a);
            chk("R2 preset carry", carry_out, s);
            chk("R2 done cleared", done, 0);
            for (int k = 1; k <= 4; k++) begin
                int mask, t;
                tick(1'b0, 1'b0, 4'd0, 4'd0);
                mask = (1 << k) - 1;
                t = (a & mask) + (beff & mask) + s;
                chk("R4 R6 partial result", result, ((t & mask) << (4 - k)) | (a >> k));
                chk("R5 step carry", carry_out, (t >> k) & 1);
                chk("R3 done timing", done, (k == 4) ? 1 : 0);
            end
            chk(s ? "R7 final result" : "R3 final result", result, v[4:1]);
            chk(s ? "R7 final carry" : "R3 final carry", carry_out, v[0]);
        end

        // R9 extra shifts after done
        tick(1'b1, 1'b0, 4'd9, 4'd8);
        for (int k = 0; k < 4; k++) tick(1'b0, 1'b0, 4'd0, 4'd0);
        for (int k = 0; k < 3; k++) tick(1'b0, 1'b1, 4'd0, 4'd0);
        chk("R9 result frozen", result, 1);
        chk("R9 carry frozen", carry_out, 1);
        chk("R9 done held", done, 1);

        // R8 sub_mode during shifts ignored
        tick(1'b1, 1'b0, 4'd3, 4'd5);
        for (int k = 0; k < 4; k++) tick(1'b0, 1'b1, 4'd0, 4'd0);
        chk("R8 add kept", result, 8);
        chk("R8 carry", carry_out, 0);

        // R11 restart mid-run
        tick(1'b1, 1'b0, 4'd9, 4'd8);
        tick(1'b0, 1'b0, 4'd0, 4'd0);
        tick(1'b0, 1'b0, 4'd0, 4'd0);
        tick(1'b1, 1'b1, 4'd6, 4'd2);
        chk("R11 new operand", result, 6);
        chk("R11 done cleared", done, 0);
        chk("R11 preset carry", carry_out, 1);
        for (int k = 0; k < 4; k++) tick(1'b0, 1'b0, 4'd0, 4'd0);
        chk("R11 result", result, 4);
        chk("R11 carry", carry_out, 1);
        chk("R11 done", done, 1);

        // R12 load held for several cycles
        tick(1'b1, 1'b0, 4'd1, 4'd1);
        tick(1'b1, 1'b0, 4'd4, 4'd7);
        tick(1'b1, 1'b0, 4'd12, 4'd3);
        chk("R12 held load", result, 12);
        chk("R12 no done", done, 0);
        for (int k = 0; k < 3; k++) tick(1'b0, 1'b0, 4'd0, 4'd0);
        chk("R12 not yet done", done, 0);
        tick(1'b0, 1'b0, 4'd0, 4'd0);
        chk("R12 result", result, 15);
        chk("R12 done", done, 1);

        // R1 reset mid-run
        tick(1'b1, 1'b1, 4'd5, 4'd1);
        tick(1'b0, 1'b0, 4'd0, 4'd0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 result after reset", result, 0);
        chk("R1 carry after reset", carry_out, 0);
        chk("R1 done after reset", done, 0);

        summary();
        $finish;
    end
endmodule